// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block works out the operand address for a processor with 16-bit memory words and two instruction lengths. A one-word instruction carries an 8-bit signed displacement. A two-word instruction carries a full 16-bit address field in its second word. A 2-bit tag picks the base that is added to the displacement or field. In the one-word form, tag 00 picks the instruction-address value, which already points past the current instruction. In the two-word form, tag 00 picks no base at all. The other three tags pick index registers, and those registers live in memory words 1, 2 and 3. The block therefore reads them through a synchronous read port with one cycle of latency.

A two-word instruction can also ask for one level of indirection. In that case the address computed directly is used to read a memory word, and that word becomes the result. Every address is cut down to the configured capacity width, which is 12 to 15 bits. Addresses therefore wrap around the top of storage.

A one-cycle start pulse loads the instruction, the address field and the instruction-address value. A one-cycle done pulse marks the cycle in which the new address first appears on the output. The output then holds that address until the next computation finishes.

Top module: `effAddrGen`

## Requirements
- R1: The format flag is instruction bit 10, with 1 meaning the two-word form. The tag is bits 9:8, and the displacement is bits 7:0. In the one-word form with tag 00, the result is the instruction-address input plus the displacement, sign-extended from bit 7.
- R2: With a nonzero tag, the base is the memory word whose address equals the tag value (1, 2 or 3). In the one-word form, the result is that word plus the sign-extended displacement.
- R3: In the two-word form with bit 7 clear, tag 00 gives the address field itself. A nonzero tag gives the indexed memory word plus the address field.
- R4: In the two-word form with bit 7 set, the direct address is read from memory, and the word read becomes the result. In the one-word form, bit 7 acts only as the displacement sign.
- R5: Base values are treated as unsigned. Only the low ADDR_W bits of every sum and of every indirect word are kept, so addresses wrap modulo 2^ADDR_W. The output is ADDR_W bits wide.
- R6: One computation issues at most two reads: one for the index fetch and one for the indirect fetch. No read is issued in the cycle where done is high. Read address bits at and above ADDR_W are zero.
- R7: done stays high for exactly one cycle. Counting the clock edge that samples start as edge 1, done rises after edge 2 + (1 if the tag is nonzero) + (2 if the access is indirect).
- R8: The output changes only in a cycle where done is high. At all other times it holds the last result.
- R9: A start pulse that arrives while a computation is in progress is ignored.
- R10: After reset, done is 0, the read enable is 0 and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; sampled only while idle |
| instrWord | input | 16 | First instruction word |
| addrField | input | 16 | Second instruction word (two-word form only) |
| iarValue | input | 16 | Instruction-address value, already advanced past the instruction |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | 16 | Memory read address |
| memRdData | input | 16 | Read data, valid one cycle after the request |
| effAddr | output | ADDR_W | Effective address result |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest case to reach is a two-word indexed indirect access, where the direct address lands back on one of the index-register words. That case needs both reads, and the second read returns an index value that the bench itself planted. The random stimulus draws small address fields with high probability, and directed cases force the address sum to equal 1, 2 or 3. A start pulse injected mid-computation also tests that the captured operands survive an overlapping start.

// File: rtl/eaPkg.sv
package eaPkg;
  localparam int FMT_BIT = 10;
  localparam int TAG_HI  = 9;
  localparam int TAG_LO  = 8;
  localparam int IND_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_XR, ST_ADD, ST_FETCH_IND, ST_LOAD_IND, ST_DONE
  } eaState_t;

  typedef struct packed {
    logic captureIn;
    logic issueXr;
    logic loadSum;
    logic issueInd;
    logic loadInd;
    logic publish;
    logic done;
  } eaStrobes_t;
endpackage

// File: rtl/eaControl.sv
module eaControl
  import eaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       hasIndex,
  input  logic       isLong,
  input  logic       isIndirect,
  output eaStrobes_t ctl
);
  eaState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctl.captureIn = 1'b1;
          stateD = hasIndex ? ST_FETCH_XR : ST_ADD;
        end
      end
      ST_FETCH_XR: begin
        ctl.issueXr = 1'b1;
        stateD = ST_ADD;
      end
      ST_ADD: begin
        ctl.loadSum = 1'b1;
        if (isLong && isIndirect) stateD = ST_FETCH_IND;
        else begin
          ctl.publish = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_FETCH_IND: begin
        ctl.issueInd = 1'b1;
        stateD = ST_LOAD_IND;
      end
      ST_LOAD_IND: begin
        ctl.loadInd = 1'b1;
        ctl.publish = 1'b1;
        stateD = ST_DONE;
      end
      ST_DONE: begin
        ctl.done = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/eaDatapath.sv
module eaDatapath
  import eaPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobes_t        ctl,
  input  logic [15:0]       instrWord,
  input  logic [15:0]       addrField,
  input  logic [15:0]       iarValue,
  input  logic [15:0]       memRdData,
  output logic              hasIndex,
  output logic              isLong,
  output logic              isIndirect,
  output logic              memRdEn,
  output logic [15:0]       memRdAddr,
  output logic [ADDR_W-1:0] effAddr
);
  localparam int PAD_W = 16 - ADDR_W;

  logic [10:0]       instrQ;
  logic [15:0]       fieldQ, iarQ;
  logic [ADDR_W-1:0] workQ, outQ;
  logic [10:0]       instrSel;
  logic [15:0]       offset16, base16, sum16;
  logic [ADDR_W-1:0] sumTrunc;

  assign instrSel   = ctl.captureIn ? instrWord[10:0] : instrQ;
  assign hasIndex   = |instrSel[TAG_HI:TAG_LO];
  assign isLong     = instrSel[FMT_BIT];
  assign isIndirect = instrSel[IND_BIT];

  always_comb begin
    offset16 = isLong ? fieldQ : {{8{instrQ[7]}}, instrQ[7:0]};
    if (hasIndex)    base16 = memRdData;
    else if (isLong) base16 = 16'h0000;
    else             base16 = iarQ;
    sum16    = base16 + offset16;
    sumTrunc = sum16[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrQ <= '0;
      fieldQ <= '0;
      iarQ   <= '0;
      workQ  <= '0;
      outQ   <= '0;
    end else begin
      if (ctl.captureIn) begin
        instrQ <= instrWord[10:0];
        fieldQ <= addrField;
        iarQ   <= iarValue;
      end
      if (ctl.loadSum) workQ <= sumTrunc;
      if (ctl.loadInd) workQ <= memRdData[ADDR_W-1:0];
      if (ctl.publish) outQ  <= ctl.loadInd ? memRdData[ADDR_W-1:0] : sumTrunc;
    end
  end

  assign memRdEn   = ctl.issueXr | ctl.issueInd;
  assign memRdAddr = ctl.issueXr ? {14'b0, instrQ[TAG_HI:TAG_LO]} : {{PAD_W{1'b0}}, workQ};
  assign effAddr   = outQ;
endmodule

// File: rtl/effAddrGen.sv
module effAddrGen
  import eaPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       instrWord,
  input  logic [15:0]       addrField,
  input  logic [15:0]       iarValue,
  output logic              memRdEn,
  output logic [15:0]       memRdAddr,
  input  logic [15:0]       memRdData,
  output logic [ADDR_W-1:0] effAddr,
  output logic              done
);
  eaStrobes_t ctl;
  logic hasIndex, isLong, isIndirect;

  eaControl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .hasIndex(hasIndex), .isLong(isLong), .isIndirect(isIndirect),
    .ctl(ctl)
  );

  eaDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .instrWord(instrWord), .addrField(addrField), .iarValue(iarValue),
    .memRdData(memRdData),
    .hasIndex(hasIndex), .isLong(isLong), .isIndirect(isIndirect),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .effAddr(effAddr)
  );

  assign done = ctl.done;
endmodule

// File: rtl/effAddrGenChk.sv
module effAddrGenChk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              memRdEn,
  input logic [15:0]       memRdAddr,
  input logic [ADDR_W-1:0] effAddr
);
  logic [1:0] readCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        readCnt <= '0;
    else if (done)    readCnt <= '0;
    else if (memRdEn) readCnt <= readCnt + 2'd1;
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_addr_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ((memRdAddr >> ADDR_W) == 16'd0));

  assert_no_read_at_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRdEn);

  assert_read_budget_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (readCnt < 2'd2));

  assert_output_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(effAddr) |-> done);
endmodule

bind effAddrGen effAddrGenChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .memRdEn(memRdEn),
  .memRdAddr(memRdAddr), .effAddr(effAddr)
);

// File: tb/effAddrGen_tb.sv
`timescale 1ns/1ps
module effAddrGen_tb;
  localparam int AW = 12;
  localparam logic [15:0] MASK = 16'((1 << AW) - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] instrWord = '0, addrField = '0, iarValue = '0;
  logic memRdEn;
  logic [15:0] memRdAddr;
  logic [15:0] memRdData = '0;
  logic [AW-1:0] effAddr;
  logic done;

  logic [15:0] xr1 = 16'h0, xr2 = 16'h0, xr3 = 16'h0;
  int checks = 0, fails = 0, reads = 0;

  always #5 clk = ~clk;

  effAddrGen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .addrField(addrField), .iarValue(iarValue), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .effAddr(effAddr), .done(done)
  );

  function automatic logic [15:0] memFn(input logic [15:0] a);
    if (a == 16'd1) return xr1;
    if (a == 16'd2) return xr2;
    if (a == 16'd3) return xr3;
    return 16'(a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memFn(memRdAddr);
      reads <= reads + 1;
    end
  end

  function automatic logic [15:0] expEa(input logic [15:0] ins, input logic [15:0] fld,
                                        input logic [15:0] iar);
    logic [1:0] tag;
    logic [15:0] base, off, d;
    tag  = ins[9:8];
    base = (tag != 2'd0) ? memFn(16'(tag)) : (ins[10] ? 16'h0 : iar);
    off  = ins[10] ? fld : {{8{ins[7]}}, ins[7:0]};
    d    = (base + off) & MASK;
    if (ins[10] && ins[7]) d = memFn(d) & MASK;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runEa(input logic [15:0] ins, input logic [15:0] fld,
                       input logic [15:0] iar, input string req, input bit pokeBusy);
    logic [15:0] exp;
    int expLat, expReads, cycles;
    logic [AW-1:0] held;
    exp      = expEa(ins, fld, iar);
    expReads = ((ins[9:8] != 2'd0) ? 1 : 0) + ((ins[10] && ins[7]) ? 1 : 0);
    expLat   = 2 + ((ins[9:8] != 2'd0) ? 1 : 0) + ((ins[10] && ins[7]) ? 2 : 0);
    @(negedge clk);
    instrWord = ins; addrField = fld; iarValue = iar; start = 1'b1;
    reads = 0;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 20) begin
      if (pokeBusy && cycles == 1) begin
        // R9: a second start while busy with different operands
        start = 1'b1; instrWord = ~ins; addrField = ~fld; iarValue = ~iar;
      end
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    check(done == 1'b1 && 16'(effAddr) == exp, req, "effective address", effAddr, exp);
    check(cycles == expLat, "R7", "done latency", cycles, expLat);
    check(reads == expReads, "R6", "read count", reads, expReads);
    held = effAddr;
    @(negedge clk);
    check(done == 1'b0, "R7", "done width", done, 0);
    @(negedge clk);
    check(effAddr == held, "R8", "output hold", effAddr, held);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1130));
    repeat (3) @(negedge clk);
    // R10: state under reset
    check(done == 1'b0, "R10", "done at reset", done, 0);
    check(memRdEn == 1'b0, "R10", "read enable at reset", memRdEn, 0);
    check(effAddr == '0, "R10", "output at reset", effAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && memRdEn == 1'b0, "R10", "idle after reset", done, 0);

    xr1 = 16'h8FF0; xr2 = 16'h0003; xr3 = 16'hFFFF;
    // R1: short, IAR base, positive and negative displacement; R5 wrap
    runEa(16'h0078, 16'h0, 16'h0501, "R1", 1'b0);
    runEa(16'h0080, 16'h0, 16'h0005, "R1", 1'b0);
    runEa(16'h0001, 16'h0, 16'h0FFF, "R5", 1'b0);
    runEa(16'h0000, 16'h0, 16'hF123, "R5", 1'b0);
    // R2: short indexed, negative index value treated unsigned
    runEa(16'h0120, 16'h0, 16'h0000, "R2", 1'b0);
    runEa(16'h03FF, 16'h0, 16'h0000, "R2", 1'b0);
    // R3: long direct
    runEa(16'h0400, 16'h1234, 16'h0777, "R3", 1'b0);
    runEa(16'h0600, 16'h0401, 16'h0000, "R3", 1'b0);
    // R4: long indirect, including landing on an index word
    runEa(16'h0480, 16'h0002, 16'h0000, "R4", 1'b0);
    runEa(16'h0680, 16'hFFFE, 16'h0000, "R4", 1'b0);
    runEa(16'h0780, 16'h0004, 16'h0000, "R4", 1'b0);
    // R4: short form bit 7 is only a sign
    runEa(16'h00FF, 16'h0002, 16'h0010, "R4", 1'b0);
    // R9: start during a busy computation
    runEa(16'h0580, 16'h0033, 16'h0000, "R9", 1'b1);
    runEa(16'h0010, 16'h0000, 16'h0100, "R9", 1'b1);

    for (int i = 0; i < 150; i++) begin
      logic [15:0] ins, fld;
      xr1 = 16'($urandom); xr2 = 16'($urandom); xr3 = 16'($urandom);
      ins = 16'($urandom);
      fld = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 5)) : 16'($urandom);
      runEa(ins, fld, 16'($urandom), "R5", ($urandom_range(0, 7) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule